// File: doc/BRIEF.md
# PHY Management Serial Master

This block is a management-bus master for an external Ethernet PHY. It is controlled through a small bank of word registers. It produces the management clock from the system clock through an even-only divider. On request it serialises one register read or register write frame on the shared data line, most significant bit first. For reads it releases the line to the PHY and captures the sixteen returned data bits.

Software programs the PHY and register address and, for a write, the data word, then writes a command. It polls the busy flag until the frame is over, then writes zero to the command register. A scan command reads the addressed PHY register again and again. From each answer it refreshes a link-fail flag, taken from the inverse of bit 2 of the returned word. An invalid flag covers the interval before the first scan result exists. A frame may be sent with its 32-bit all-ones preamble or without it.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The management clock period is twice the value of mode bits 7:1 in system clock cycles, so mode bit 0 never affects it. A value of 0 in bits 7:1 gives a period of 2 cycles.
- R2: Each frame starts with 32 driven ones when mode bit 8 is 0. It starts directly with the start pattern when mode bit 8 is 1.
- R3: A write frame drives, in order: start 01, opcode 01, 5 PHY address bits, 5 register address bits, turnaround 10, and the 16 transmit-data bits. All fields are sent MSB first, and each bit changes on a falling edge of the management clock.
- R4: A read frame drives start 01, opcode 10 and both addresses. It then holds the output enable low through the turnaround and the 16 data bits. It samples the input on rising clock edges, and the captured word appears in the receive-data register.
- R5: Status bit 1 (busy) reads 1 from the cycle after an accepted command until the frame ends. During a scan it stays 1 until the last scan frame ends.
- R6: Command bit 2 starts a write, bit 1 a read and bit 0 a scan, with priority in that order. A command written while busy starts nothing.
- R7: A scan repeats reads of the addressed register while command bit 0 stays set. After each scan frame, status bit 0 (link fail) equals the inverse of bit 2 of the returned word. Status bit 2 (invalid) is 1 from the scan command until the first scan frame ends.
- R8: The address register holds the PHY address in bits 4:0 and the register address in bits 12:8. The transmit-data and receive-data registers use bits 15:0.
- R9: After reset every register reads 0, the management clock is low and the output enable is low.
- R10: Register index 0 is mode, 1 command, 2 address, 3 transmit data, 4 receive data and 5 status. A readback of a writable register returns only its defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | High while the master drives the data line |
| mdio_in | input | 1 | Serial data from the shared line |

## Verification
A wrong bit counter or frame latch shows on the serial line within the frame it corrupts. A stuck counter also holds busy high forever. A field misplaced in a register shows in the PHY model's decode of the very next frame. A bad divider shows as a wrong clock period within two periods of a mode write. A wrong capture or scan update reaches the receive-data or status register at the cycle the frame ends. The bench checks it there, with expected values computed from the responder's register model.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int DIV_W     = 8;
  localparam int HALF_W    = DIV_W - 1;
  localparam int FIELD_W   = 5;
  localparam int WORD_W    = 16;
  localparam int BODY_W    = 32;
  localparam int POS_W     = 6;
  localparam int TA_HI     = 17;
  localparam int LINK_BIT  = 2;

  localparam logic [2:0] IDX_MODE = 3'd0;
  localparam logic [2:0] IDX_CMD  = 3'd1;
  localparam logic [2:0] IDX_ADDR = 3'd2;
  localparam logic [2:0] IDX_TXD  = 3'd3;
  localparam logic [2:0] IDX_RXD  = 3'd4;
  localparam logic [2:0] IDX_STAT = 3'd5;

  localparam int CMD_SCAN = 0;
  localparam int CMD_READ = 1;
  localparam int CMD_WRITE = 2;

  function automatic logic [HALF_W-1:0] half_period(input logic [DIV_W-1:0] d);
    return (d[DIV_W-1:1] == '0) ? HALF_W'(1) : d[DIV_W-1:1];
  endfunction

  function automatic logic [BODY_W-1:0] build_body(input logic is_read,
                                                   input logic [FIELD_W-1:0] phy,
                                                   input logic [FIELD_W-1:0] rga,
                                                   input logic [WORD_W-1:0] wd);
    return {2'b01, is_read ? 2'b10 : 2'b01, phy, rga,
            is_read ? 2'b11 : 2'b10, is_read ? WORD_W'(0) : wd};
  endfunction

  function automatic logic frame_bit(input logic [BODY_W-1:0] body,
                                     input logic [POS_W-1:0] pos);
    return pos[POS_W-1] ? 1'b1 : body[pos[POS_W-2:0]];
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half;
  logic              tick;

  assign half     = half_period(div_sel);
  assign tick     = (cnt_q >= half - HALF_W'(1));
  assign rise_stb = tick & ~mdc;
  assign fall_stb = tick & mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + HALF_W'(1);
      if (tick) mdc <= ~mdc;
    end
  end

  AST_MDC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc); // R1
  AST_MDC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !mdc); // R1
  AST_MDC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_stb && !fall_stb) |=> $stable(mdc)); // R1
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_stb,
  input  logic               fall_stb,
  input  logic               launch,
  input  logic               op_read,
  input  logic               no_pre,
  input  logic [FIELD_W-1:0] phy_ad,
  input  logic [FIELD_W-1:0] reg_ad,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               mdio_in,
  output logic               mdio_out,
  output logic               mdio_oe,
  output logic               active,
  output logic               frame_done,
  output logic [WORD_W-1:0]  rd_data
);
  logic [BODY_W-1:0] body_q, body_nx;
  logic [POS_W-1:0]  pos_q, pos_nx;
  logic              rd_q;
  logic [WORD_W-1:0] cap_q;

  assign frame_done = active & fall_stb & (pos_q == '0);
  assign rd_data    = cap_q;

  always_comb begin
    body_nx = build_body(op_read, phy_ad, reg_ad, wr_data);
    if (launch) pos_nx = no_pre ? POS_W'(BODY_W - 1) : POS_W'(2 * BODY_W - 1);
    else        pos_nx = pos_q - POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      body_q   <= '0;
      pos_q    <= '0;
      rd_q     <= 1'b0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
      cap_q    <= '0;
    end else begin
      if (launch) begin
        active   <= 1'b1;
        body_q   <= body_nx;
        rd_q     <= op_read;
        pos_q    <= pos_nx;
        mdio_out <= frame_bit(body_nx, pos_nx);
        mdio_oe  <= !(op_read && pos_nx <= POS_W'(TA_HI));
      end else if (frame_done) begin
        active   <= 1'b0;
        mdio_out <= 1'b1;
        mdio_oe  <= 1'b0;
      end else if (active && fall_stb) begin
        pos_q    <= pos_nx;
        mdio_out <= frame_bit(body_q, pos_nx);
        mdio_oe  <= !(rd_q && pos_nx <= POS_W'(TA_HI));
      end
      if (active && rise_stb && rd_q && pos_q < POS_W'(WORD_W))
        cap_q[pos_q[3:0]] <= mdio_in;
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_q && pos_q <= POS_W'(TA_HI)) |-> !mdio_oe); // R4
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fall_stb) |=> $stable(mdio_out)); // R3
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !mdio_oe); // R9
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic [DIV_W:0]     mode_q;
  logic [2:0]         cmd_q;
  logic [FIELD_W-1:0] phy_q, rga_q;
  logic [WORD_W-1:0]  txd_q, rxd_q;
  logic               link_fail_q, invalid_q, req_q, rd_op_q, scan_q;
  logic               rise_stb, fall_stb, active, frame_done, launch, busy;
  logic               cmd_wr, accept, scan_req;
  logic [WORD_W-1:0]  rd_data;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^reg_wdata[31:16];
  assign busy     = req_q | active;
  assign launch   = req_q & fall_stb & ~active;
  assign cmd_wr   = reg_wr && reg_addr == IDX_CMD;
  assign accept   = cmd_wr && !busy && (reg_wdata[2:0] != 3'b000);
  assign scan_req = !reg_wdata[CMD_WRITE] && !reg_wdata[CMD_READ] && reg_wdata[CMD_SCAN];

  mdio_clk_div u_div (
    .clk(clk), .rst_n(rst_n), .div_sel(mode_q[DIV_W-1:0]),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .launch(launch), .op_read(rd_op_q), .no_pre(mode_q[DIV_W]),
    .phy_ad(phy_q), .reg_ad(rga_q), .wr_data(txd_q), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .active(active),
    .frame_done(frame_done), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= '0;
      cmd_q       <= '0;
      phy_q       <= '0;
      rga_q       <= '0;
      txd_q       <= '0;
      rxd_q       <= '0;
      link_fail_q <= 1'b0;
      invalid_q   <= 1'b0;
      req_q       <= 1'b0;
      rd_op_q     <= 1'b0;
      scan_q      <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == IDX_MODE) mode_q <= reg_wdata[DIV_W:0];
      if (reg_wr && reg_addr == IDX_ADDR) begin
        phy_q <= reg_wdata[FIELD_W-1:0];
        rga_q <= reg_wdata[8 +: FIELD_W];
      end
      if (reg_wr && reg_addr == IDX_TXD) txd_q <= reg_wdata[WORD_W-1:0];
      if (cmd_wr) cmd_q <= reg_wdata[2:0];
      if (accept) begin
        req_q   <= 1'b1;
        rd_op_q <= !reg_wdata[CMD_WRITE];
        scan_q  <= scan_req;
        if (scan_req) invalid_q <= 1'b1;
      end else if (launch) begin
        req_q <= 1'b0;
      end
      if (frame_done) begin
        if (rd_op_q) rxd_q <= rd_data;
        if (scan_q) begin
          link_fail_q <= ~rd_data[LINK_BIT];
          invalid_q   <= 1'b0;
          if (cmd_q[CMD_SCAN]) req_q  <= 1'b1;
          else                 scan_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      IDX_MODE: reg_rdata = {{(31 - DIV_W){1'b0}}, mode_q};
      IDX_CMD:  reg_rdata = {29'b0, cmd_q};
      IDX_ADDR: reg_rdata = {19'b0, rga_q, 3'b0, phy_q};
      IDX_TXD:  reg_rdata = {16'b0, txd_q};
      IDX_RXD:  reg_rdata = {16'b0, rxd_q};
      IDX_STAT: reg_rdata = {29'b0, invalid_q, busy, link_fail_q};
      default:  reg_rdata = '0;
    endcase
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> busy); // R5
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R5
  AST_INVALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(invalid_q) |-> $past(frame_done)); // R7
  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> !active); // R6
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        phy_drv = 1'b1;

  mdio_mgmt_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(phy_drv)
  );

  always #2 clk = ~clk;

  int n_checks = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY responder model
  logic [15:0] model [32];
  int st = 0, ones = 0, nb = 0, k = 0, frames = 0, last_pre = 0, oe_bad = 0;
  logic [13:0] hdr;
  logic [17:0] wtail;
  logic [1:0]  last_op, last_ta;
  logic [4:0]  last_phy, last_reg;
  logic [15:0] last_wd;

  always @(posedge mdc) begin
    case (st)
      0: if (mdio_oe) begin
           if (mdio_out) ones++;
           else begin hdr = '0; nb = 1; st = 1; last_pre = ones; ones = 0; end
         end
      1: begin
           hdr = {hdr[12:0], mdio_out}; nb++;
           if (nb == 14) begin
             last_op = hdr[11:10]; last_phy = hdr[9:5]; last_reg = hdr[4:0];
             if (hdr[11:10] == 2'b10) begin st = 3; k = 0; end
             else begin st = 2; nb = 0; end
           end
         end
      2: begin
           wtail = {wtail[16:0], mdio_out}; nb++;
           if (nb == 18) begin
             last_ta = wtail[17:16]; last_wd = wtail[15:0];
             model[last_reg] = wtail[15:0]; frames++; st = 0;
           end
         end
      3: if (mdio_oe) oe_bad++;
      default: st = 0;
    endcase
  end

  always @(negedge mdc) begin
    if (st == 3) begin
      k++;
      if (k == 1)      phy_drv = 1'b1;
      else if (k == 2) phy_drv = 1'b0;
      else if (k <= 18) phy_drv = model[last_reg][18 - k];
      else begin phy_drv = 1'b1; frames++; st = 0; end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    rd_reg(3'd5, s);
    while (s[1]) rd_reg(3'd5, s);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input logic nopre);
    logic [31:0] s;
    int f0;
    wr_reg(3'd0, {23'b0, nopre, 8'd4});
    wr_reg(3'd2, {19'b0, rg, 3'b0, phy});
    wr_reg(3'd3, {16'b0, d});
    f0 = frames;
    wr_reg(3'd1, 32'h4);
    rd_reg(3'd5, s);
    chk("R5 busy after write cmd", {31'b0, s[1]}, 32'd1);
    wait_idle();
    wr_reg(3'd1, 32'h0);
    chk("R3 one write frame", frames, f0 + 1);
    chk("R3 opcode", {30'b0, last_op}, 32'd1);
    chk("R3 turnaround", {30'b0, last_ta}, 32'd2);
    chk("R8 phy field", {27'b0, last_phy}, {27'b0, phy});
    chk("R8 reg field", {27'b0, last_reg}, {27'b0, rg});
    chk("R3 data", {16'b0, last_wd}, {16'b0, d});
    chk("R2 preamble length", last_pre, nopre ? 0 : 32);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic nopre);
    logic [31:0] s;
    int f0, b0;
    wr_reg(3'd0, {23'b0, nopre, 8'd4});
    wr_reg(3'd2, {19'b0, rg, 3'b0, phy});
    f0 = frames; b0 = oe_bad;
    wr_reg(3'd1, 32'h2);
    rd_reg(3'd5, s);
    chk("R5 busy after read cmd", {31'b0, s[1]}, 32'd1);
    wait_idle();
    wr_reg(3'd1, 32'h0);
    chk("R4 one read frame", frames, f0 + 1);
    chk("R4 opcode", {30'b0, last_op}, 32'd2);
    chk("R4 released line", oe_bad, b0);
    chk("R2 preamble length", last_pre, nopre ? 0 : 32);
    rd_reg(3'd4, s);
    chk("R4 captured data", s, {16'b0, model[rg]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    real t1, per;
    int expp, f1, rx0;
    for (int i = 0; i < 32; i++) model[i] = 16'(i * 16'h1357 + 16'h0F0F);
    repeat (4) @(negedge clk);
    chk("R9 mdc low in reset", {31'b0, mdc}, 32'd0);
    chk("R9 oe low in reset", {31'b0, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), s);
      chk("R9 register zero after reset", s, 32'd0);
    end

    // R10 register map and field masks
    wr_reg(3'd0, 32'hFFFF_FFFF); rd_reg(3'd0, s); chk("R10 mode readback", s, 32'h1FF);
    wr_reg(3'd2, 32'hFFFF_FFFF); rd_reg(3'd2, s); chk("R10 R8 address readback", s, 32'h1F1F);
    wr_reg(3'd3, 32'hABCD_1234); rd_reg(3'd3, s); chk("R10 R8 txdata readback", s, 32'h1234);
    wr_reg(3'd4, 32'hFFFF_FFFF); rd_reg(3'd4, s); chk("R10 rxdata read-only", s, 32'h0);

    // R1 divider sweep
    for (int d = 0; d < 34; d++) begin
      int dv;
      dv = (d < 32) ? d : 222 + d;
      wr_reg(3'd0, 32'(dv));
      @(posedge mdc); @(posedge mdc);
      t1 = $realtime;
      @(posedge mdc);
      per = ($realtime - t1) / 4.0;
      expp = ((dv >> 1) == 0) ? 2 : (dv & ~1);
      chk("R1 mdc period", int'(per), expp);
    end

    // R2 R3 R8 write frames
    do_write(5'd0, 5'd0, 16'h0000, 1'b0);
    do_write(5'd31, 5'd31, 16'hFFFF, 1'b1);
    for (int i = 0; i < 6; i++)
      do_write(5'(i * 7 + 1), 5'(i * 3 + 2), 16'(16'hA5C3 ^ (16'h1 << (i * 3))), 1'(i & 1));

    // R4 read frames
    model[9] = 16'h0000; model[10] = 16'hFFFF; model[11] = 16'h8001;
    do_read(5'd1, 5'd9, 1'b0);
    do_read(5'd2, 5'd10, 1'b1);
    do_read(5'd3, 5'd11, 1'b0);
    do_read(5'd4, 5'd12, 1'b1);

    // R6 command while busy is ignored
    rd_reg(3'd4, s); rx0 = int'(s);
    wr_reg(3'd0, 32'd4);
    wr_reg(3'd2, {19'b0, 5'd6, 3'b0, 5'd5});
    wr_reg(3'd3, 32'h0000_3C3C);
    f1 = frames;
    wr_reg(3'd1, 32'h4);
    wr_reg(3'd1, 32'h2);
    wait_idle();
    wr_reg(3'd1, 32'h0);
    repeat (300) @(posedge clk);
    chk("R6 only one frame", frames, f1 + 1);
    chk("R6 frame was write", {30'b0, last_op}, 32'd1);
    rd_reg(3'd4, s);
    chk("R6 rxdata untouched", s, 32'(rx0));

    // R7 scan
    model[1] = 16'h0000;
    wr_reg(3'd2, {19'b0, 5'd1, 3'b0, 5'd3});
    f1 = frames;
    wr_reg(3'd1, 32'h1);
    rd_reg(3'd5, s);
    chk("R7 invalid and busy at scan start", s, 32'h6);
    while (frames < f1 + 1) @(posedge clk);
    rd_reg(3'd5, s);
    chk("R7 link fail after first scan", s, 32'h3);
    chk("R7 scan phy address", {27'b0, last_phy}, 32'd3);
    model[1] = 16'h0004;
    while (frames < f1 + 3) @(posedge clk);
    rd_reg(3'd5, s);
    chk("R7 link good after update", s, 32'h2);
    wr_reg(3'd1, 32'h0);
    wait_idle();
    f1 = frames;
    repeat (1000) @(posedge clk);
    chk("R7 scan stopped", frames, f1);
    rd_reg(3'd4, s);
    chk("R7 scan data in rxdata", s, 32'h0004);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule